// File: doc/BRIEF.md
# Banked Divisor Baud-Rate Generator

This block produces the sampling tick for a serial port. It divides the system clock by a 16-bit divisor and emits a one-cycle pulse at sixteen times the baud rate. With a 1.8432 MHz input clock, a divisor of 6 gives 19200 baud, 12 gives 9600, 24 gives 4800, 48 gives 2400, 96 gives 1200 and 384 gives 300.

The divisor is reached through a small register window. It shares its two offsets with the receive/transmit data buffer and the interrupt-enable register. A single bank bit, the most significant bit of the line-control word at offset 3, picks what those offsets reach:

- When the bank bit is clear, the block does not hold the buffer or the interrupt-enable register. It asserts a select line so that the neighbouring logic can serve the access.
- When the bank bit is set, offset 0 holds the low divisor byte and offset 1 holds the high byte.

Top module: `baud_divisor_bank`

## Requirements
- R1: After reset, the line-control word and the divisor read as 0 and `tick` stays low.
- R2: Offset 3 holds an 8-bit line-control word. All eight bits can be written and read back, and bit 7 is the bank bit.
- R3: With bank bit 7 set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. Neither select line is asserted.
- R4: With bank bit 7 clear, an access to offset 0 asserts `sel_data_buf` and an access to offset 1 asserts `sel_int_en`. Writes there leave the divisor unchanged, and reads there return 0 from this block.
- R5: With divisor D greater than 1, `tick` is a one-cycle pulse that repeats every D clock cycles.
- R6: Divisor 1 makes `tick` high on every cycle. Divisor 0 keeps `tick` low.
- R7: A write to either divisor byte restarts the count. `tick` is low in the cycle after the write, and the first pulse comes D cycles after the write edge.
- R8: Offsets 2, 4, 5, 6 and 7 read 0, assert no select line, and change no state.
- R9: `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which the divisor divides |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from offset and strobe |
| tick | output | 1 | One-cycle pulse at sixteen times the baud rate |
| sel_data_buf | output | 1 | Access to offset 0 with the bank bit clear |
| sel_int_en | output | 1 | Access to offset 1 with the bank bit clear |

## Verification
The assertions take the offset and strobes to be known values that hold steady from one rising edge to the next. They also take reset to be held across at least one edge, so that the hold checks on the line-control word and the divisor start from a defined value. The bench changes every input only on the falling clock edge. It mixes random offsets and strobes with directed sequences, and it biases divisor writes toward small values so that many tick periods, reloads in mid-period, and the divisors 0 and 1 all occur within the run.

// File: rtl/baudgen_pkg.sv
// Package: shared offsets and decode target type for the banked baud generator.
// Assumes an 8-bit register window and a divisor made of exactly two bytes.
package baudgen_pkg;

    // Register offsets that neighbouring logic decodes; their positions are fixed.
    localparam int unsigned OFS_LOW_BANK  = 0;
    localparam int unsigned OFS_HIGH_BANK = 1;
    localparam int unsigned OFS_LINE_CTRL = 3;

    // Number of bytes that make up the divisor.
    localparam int unsigned DIV_BYTES = 2;

    // Resolved meaning of one register access.
    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_DIV_LO = 3'd1,
        TGT_DIV_HI = 3'd2,
        TGT_LINE   = 3'd3,
        TGT_BUF    = 3'd4,
        TGT_IER    = 3'd5
    } target_e;

endpackage

// File: rtl/baudgen_decode.sv
// Module: baudgen_decode
// Resolves an offset plus the bank bit into one access target, and drives
// the pass-through select lines for the data buffer and interrupt enable.
// Assumes at most one register access per cycle.
module baudgen_decode
    import baudgen_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              bank_sel,
    output target_e           target,
    output logic              sel_data_buf,
    output logic              sel_int_en
);

    localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(OFS_LOW_BANK);
    localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(OFS_HIGH_BANK);
    localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFS_LINE_CTRL);

    logic access;

    // Purpose: flag any access, read or write, in this cycle.
    assign access = wr_en | rd_en;

    // Purpose: map the offset and the bank bit to a target.
    always_comb begin
        target = TGT_NONE;
        if (addr == A_LOW) begin
            target = bank_sel ? TGT_DIV_LO : TGT_BUF;
        end else if (addr == A_HIGH) begin
            target = bank_sel ? TGT_DIV_HI : TGT_IER;
        end else if (addr == A_LINE) begin
            target = TGT_LINE;
        end
    end

    // Purpose: raise the pass-through selects only while an access is active.
    always_comb begin
        sel_data_buf = access && (target == TGT_BUF);
        sel_int_en   = access && (target == TGT_IER);
    end

endmodule

// File: rtl/baudgen_regs.sv
// Module: baudgen_regs
// Holds the line-control word and the divisor bytes. It also exposes the
// divisor value that applies after this edge, plus a load pulse, so that
// the counter can restart with the new value in the same edge.
// Assumes that target is already gated by the offset decode.
module baudgen_regs
    import baudgen_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned DIV_W = DIV_BYTES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  target_e           target,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lcr_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  div_next,
    output logic              div_load
);

    logic [DIV_BYTES-1:0] byte_we;

    // Purpose: store the line-control word; it clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q <= '0;
        end else if (wr_en && (target == TGT_LINE)) begin
            lcr_q <= wdata;
        end
    end

    for (genvar gi = 0; gi < DIV_BYTES; gi++) begin : g_div_byte
        localparam target_e HIT = (gi == 0) ? TGT_DIV_LO : TGT_DIV_HI;

        // Purpose: write enable for this divisor byte.
        assign byte_we[gi] = wr_en && (target == HIT);

        // Purpose: value of this byte after the current edge.
        assign div_next[gi*DATA_W +: DATA_W] =
            byte_we[gi] ? wdata : div_q[gi*DATA_W +: DATA_W];

        // Purpose: store this divisor byte; it clears on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                div_q[gi*DATA_W +: DATA_W] <= '0;
            end else if (byte_we[gi]) begin
                div_q[gi*DATA_W +: DATA_W] <= wdata;
            end
        end
    end

    // Purpose: a write to any divisor byte restarts the count.
    assign div_load = |byte_we;

endmodule

// File: rtl/baudgen_counter.sv
// Module: baudgen_counter
// Down-counter that divides the clock by the divisor and gives a registered
// one-cycle tick each time it wraps. A load restarts it from the new value.
// Assumes that div_next equals div_q whenever div_load is low.
module baudgen_counter #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_q,
    input  logic [DIV_W-1:0] div_next,
    input  logic             div_load,
    output logic             tick
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;

    // Purpose: count down, reload on a wrap or a divisor write, and pulse the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (div_load) begin
            cnt_q <= (div_next == '0) ? '0 : div_next - ONE;
            tick  <= 1'b0;
        end else if (div_q == '0) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q <= div_q - ONE;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q - ONE;
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/baud_divisor_bank.sv
// Module: baud_divisor_bank (top)
// Register window for a baud-rate generator whose divisor shares offsets
// with the data buffer and interrupt enable, banked by line-control bit 7.
// Assumes a single-cycle access protocol and a synchronous active-low reset.
module baud_divisor_bank
    import baudgen_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned DIV_W = DIV_BYTES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tick,
    output logic              sel_data_buf,
    output logic              sel_int_en
);

    target_e          target;
    logic [DATA_W-1:0] lcr_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  div_next;
    logic              div_load;
    logic              bank_sel;

    // Purpose: the top bit of the line-control word selects the divisor bank.
    assign bank_sel = lcr_q[DATA_W-1];

    baudgen_decode #(.ADDR_W(ADDR_W)) decode_i (
        .addr         (addr),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .bank_sel     (bank_sel),
        .target       (target),
        .sel_data_buf (sel_data_buf),
        .sel_int_en   (sel_int_en)
    );

    baudgen_regs #(.DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .target   (target),
        .wdata    (wdata),
        .lcr_q    (lcr_q),
        .div_q    (div_q),
        .div_next (div_next),
        .div_load (div_load)
    );

    baudgen_counter #(.DIV_W(DIV_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_q    (div_q),
        .div_next (div_next),
        .div_load (div_load),
        .tick     (tick)
    );

    // Purpose: return data for the registers held here, and 0 otherwise.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (target)
                TGT_DIV_LO: rdata = div_q[DATA_W-1:0];
                TGT_DIV_HI: rdata = div_q[DIV_W-1:DATA_W];
                TGT_LINE:   rdata = lcr_q;
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/baudgen_checker.sv
// Module: baudgen_checker
// Property checks for baud_divisor_bank, attached by bind. It observes the
// ports plus the register outputs and the load pulse between sub-blocks.
module baudgen_checker #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              tick,
    input logic              sel_data_buf,
    input logic              sel_int_en,
    input logic [DATA_W-1:0] lcr_q,
    input logic [DIV_W-1:0]  div_q,
    input logic              div_load
);

    p_sel_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_data_buf, sel_int_en}));

    p_buf_sel_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_data_buf |-> ((wr_en || rd_en) && addr == ADDR_W'(0) && !lcr_q[DATA_W-1]));

    p_ier_sel_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_int_en |-> ((wr_en || rd_en) && addr == ADDR_W'(1) && !lcr_q[DATA_W-1]));

    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

    p_lcr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(3)) |=> $stable(lcr_q));

    p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && lcr_q[DATA_W-1] && addr < ADDR_W'(2)) |=> $stable(div_q));

    p_zero_div_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0 && !div_load) |=> !tick);

    p_unit_div_every_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == DIV_W'(1) && !div_load) |=> tick);

    p_load_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> !tick);

    p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_q > DIV_W'(1)) |=> !tick);

endmodule

bind baud_divisor_bank baudgen_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rdata        (rdata),
    .tick         (tick),
    .sel_data_buf (sel_data_buf),
    .sel_int_en   (sel_int_en),
    .lcr_q        (lcr_q),
    .div_q        (div_q),
    .div_load     (div_load)
);

// File: tb/baud_divisor_bank_tb_top.sv
`timescale 1ns/1ps
// Bench for baud_divisor_bank. A behavioural model built from the
// requirements updates on each rising edge; outputs are compared on the
// falling edge, and combinational outputs 1 ns after the inputs change.
module baud_divisor_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick;
    logic       sel_data_buf;
    logic       sel_int_en;

    int n_checks = 0;
    int n_fails  = 0;

    // Model state
    logic [7:0]  m_lcr = '0;
    logic [15:0] m_div = '0;
    int          m_since = 0;
    logic        m_tick = 1'b0;
    logic        m_hit;

    always #2 clk = ~clk;

    baud_divisor_bank dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .wdata        (wdata),
        .rdata        (rdata),
        .tick         (tick),
        .sel_data_buf (sel_data_buf),
        .sel_int_en   (sel_int_en)
    );

    // Model: a tick follows every D-th edge after the latest divisor write.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lcr   = '0;
            m_div   = '0;
            m_since = 0;
        end else begin
            m_hit = 1'b0;
            if (wr_en && m_lcr[7] && addr == 3'd0) begin m_div[7:0]  = wdata; m_hit = 1'b1; end
            if (wr_en && m_lcr[7] && addr == 3'd1) begin m_div[15:8] = wdata; m_hit = 1'b1; end
            if (wr_en && addr == 3'd3) m_lcr = wdata;
            if (m_hit) m_since = 0; else m_since = m_since + 1;
        end
        m_tick = rst_n && (m_div != 0) && (m_since > 0) && ((m_since % int'(m_div)) == 0);
    end

    function automatic logic [7:0] exp_rdata(logic [2:0] a, logic rd);
        if (!rd) return 8'h00;                                  // R9
        if (a == 3'd3) return m_lcr;                            // R2
        if (a == 3'd0 && m_lcr[7]) return m_div[7:0];           // R3
        if (a == 3'd1 && m_lcr[7]) return m_div[15:8];          // R3
        return 8'h00;                                           // R4, R8
    endfunction

    function automatic logic exp_buf(logic [2:0] a, logic acc);
        return acc && a == 3'd0 && !m_lcr[7];
    endfunction

    function automatic logic exp_ier(logic [2:0] a, logic acc);
        return acc && a == 3'd1 && !m_lcr[7];
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: check tick, apply inputs, then check combinational outputs.
    task automatic step(logic [2:0] a, logic w, logic r, logic [7:0] d, string tag);
        @(negedge clk);
        check({tag, " tick R5 R6 R7"}, {15'd0, tick}, {15'd0, m_tick});
        addr = a; wr_en = w; rd_en = r; wdata = d;
        #1;
        check({tag, " rdata R9"}, {8'd0, rdata}, {8'd0, exp_rdata(a, r)});
        check({tag, " sel_data_buf R4"}, {15'd0, sel_data_buf}, {15'd0, exp_buf(a, w | r)});
        check({tag, " sel_int_en R4"}, {15'd0, sel_int_en}, {15'd0, exp_ier(a, w | r)});
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(3'd0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    task automatic set_div(logic [15:0] d);
        step(3'd3, 1'b1, 1'b0, 8'h83, "R3 bank on");
        step(3'd1, 1'b1, 1'b0, d[15:8], "R3 hi");
        step(3'd0, 1'b1, 1'b0, d[7:0], "R3 lo");
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(4 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step(3'd3, 1'b0, 1'b1, 8'h00, "R1 lcr");
        step(3'd0, 1'b0, 1'b1, 8'h00, "R1 buf");
        step(3'd3, 1'b1, 1'b0, 8'h80, "R1 bank on");
        step(3'd0, 1'b0, 1'b1, 8'h00, "R1 div lo");
        step(3'd1, 1'b0, 1'b1, 8'h00, "R1 div hi");
        idle(10, "R1 quiet");

        // R2: line-control word round trip
        step(3'd3, 1'b1, 1'b0, 8'h5A, "R2 wr");
        step(3'd3, 1'b0, 1'b1, 8'h00, "R2 rd");
        step(3'd3, 1'b1, 1'b0, 8'hA5, "R2 wr2");
        step(3'd3, 1'b0, 1'b1, 8'h00, "R2 rd2");

        // R3, R5: divisor 6 and readback
        set_div(16'd6);
        step(3'd0, 1'b0, 1'b1, 8'h00, "R3 rd lo");
        step(3'd1, 1'b0, 1'b1, 8'h00, "R3 rd hi");
        idle(30, "R5 div6");

        // R4: bank off, pass-through, divisor untouched
        step(3'd3, 1'b1, 1'b0, 8'h03, "R4 bank off");
        step(3'd0, 1'b1, 1'b0, 8'hFF, "R4 buf wr");
        step(3'd1, 1'b1, 1'b0, 8'hFF, "R4 ier wr");
        step(3'd0, 1'b0, 1'b1, 8'h00, "R4 buf rd");
        step(3'd1, 1'b0, 1'b1, 8'h00, "R4 ier rd");
        step(3'd3, 1'b1, 1'b0, 8'h83, "R4 bank on");
        step(3'd0, 1'b0, 1'b1, 8'h00, "R4 div kept");
        idle(14, "R5 div6 again");

        // R6: divisor 1 and 0
        set_div(16'd1);
        idle(8, "R6 div1");
        set_div(16'd0);
        idle(12, "R6 div0");

        // R7: reload mid-period, and a larger divisor
        set_div(16'd10);
        idle(4, "R7 part");
        step(3'd0, 1'b1, 1'b0, 8'd5, "R7 reload");
        idle(22, "R7 after");
        set_div(16'd384);
        idle(800, "R5 div384");

        // R8: unused offsets
        for (int a = 2; a < 8; a++) begin
            if (a != 3) begin
                step(3'(a), 1'b1, 1'b0, 8'hFF, "R8 wr");
                step(3'(a), 1'b0, 1'b1, 8'h00, "R8 rd");
            end
        end
        step(3'd3, 1'b0, 1'b1, 8'h00, "R8 lcr kept");
        step(3'd1, 1'b1, 1'b1, 8'h00, "R9 wr rd");

        // Random phase with small divisors favoured
        for (int i = 0; i < 4000; i++) begin
            int unsigned op = $urandom % 16;
            logic [7:0] d = 8'($urandom);
            case (op)
                0, 1:    step(3'd3, 1'b1, 1'($urandom % 2), d, "rnd lcr R2");
                2, 3, 4: step(3'd0, 1'b1, 1'b0, 8'($urandom % 12), "rnd lo R3");
                5:       step(3'd1, 1'b1, 1'b0, ($urandom % 8 == 0) ? d : 8'h00, "rnd hi R3");
                6, 7, 8: step(3'($urandom), 1'b0, 1'b1, d, "rnd rd R8");
                9:       step(3'($urandom), 1'b0, 1'b0, d, "rnd nostrobe R9");
                default: idle(1, "rnd idle R5");
            endcase
        end
        idle(4, "end");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule